// File: doc/BRIEF.md
# Reference-Clocked VCO Band Calibrator and Drift Monitor

This block chooses a coarse tuning code for a VCO before the phase loop tries to lock. It also watches the VCO frequency while the loop is locked. It measures frequency by counting pulses of the divided VCO clock over a window of a fixed number of reference-clock pulses. The reference clock is nominally 25 MHz. Both pulse streams arrive already synchronized to the block clock, as single-cycle enables `ref_tick` and `vco_tick`.

The calibration sweep runs after reset, and again whenever the reference-path setting becomes `2'b11`. It tries every coarse code in turn, starting from 0. It stores the code whose count lies nearest the programmed target, so the loop can start directly on that code. Once calibration is complete and the loop reports lock, each window's count is compared against a band of target ± tolerance. Two out-of-band windows in a row raise a sticky interrupt for the system controller to service.

States and transitions:

| State | Meaning |
|-------|---------|
| `ST_OFF` | Inactive, all outputs cleared. |
| `ST_SWEEP` | One window is measured per code. |
| `ST_READY` | Calibration is done; the block waits for lock. |
| `ST_WATCH` | The block monitors drift. |

| Transition | Condition |
|------------|-----------|
| OFF→SWEEP | Setting equals `11`. |
| SWEEP→READY | The window of the last code closes. |
| READY→WATCH | `locked` is high. |
| WATCH→READY | `locked` is low. |
| any→OFF | Setting differs from `11`, or reset. |

Top module: `vcal_monitor`

## Requirements
- R1: While `rst_n` is low, `coarse_code` is 0 and `cal_done` and `drift_irq` are 0. After release, with `ref_mode` = `2'b11`, a sweep starts at code 0.
- R2: During the sweep, each code is driven on `coarse_code` for one window of `WIN_REFS` `ref_tick` pulses. The code increments by one on the edge after the pulse that closes its window.
- R3: When the last code's window closes, `coarse_code` takes the code with the smallest absolute difference between count and `target`, and `cal_done` rises on the same edge. On a tie, the lower code wins.
- R4: Any `ref_mode` value other than `2'b11` makes the block inactive from the next edge: `coarse_code` is 0 and `cal_done` and `drift_irq` are 0. A later return to `2'b11` restarts the sweep from code 0.
- R5: Drift is judged only in `ST_WATCH` while `locked` is high. A low `locked` returns the block to `ST_READY`, where no window is judged and the streak of misses is cleared.
- R6: A window is out of band when count > `target` + `tolerance` or count < `target` − `tolerance`; the band edges count as in band. `drift_irq` sets on the edge after the second consecutive out-of-band window closes. A single out-of-band window does not set it.
- R7: `drift_irq` stays set until a cycle with `irq_clr` high clears it on the following edge. If a set and a clear fall in the same cycle, the set wins.
- R8: The VCO pulse count saturates at 2^`CNT_W`−1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_mode | input | 2 | Reference path setting; only `2'b11` enables the block |
| ref_tick | input | 1 | One pulse per reference clock cycle |
| vco_tick | input | 1 | One pulse per divided VCO cycle |
| locked | input | 1 | Phase loop lock indication |
| target | input | CNT_W | Expected count per window |
| tolerance | input | CNT_W | Half-width of the acceptance band |
| irq_clr | input | 1 | Write-one-to-clear for `drift_irq` |
| coarse_code | output | CODE_W | Coarse tuning code driven to the VCO |
| cal_done | output | 1 | Calibration result valid |
| drift_irq | output | 1 | Sticky frequency-drift interrupt |

## Verification
Every output is registered. A window that closes on edge N therefore shows its result (a code step, the chosen code with `cal_done`, or a new `drift_irq`) just after edge N+1's predecessor, that is, in the cycle following edge N. A change of `ref_mode` or a pulse on `irq_clr` likewise appears one edge later. The bench keeps a behavioural model, advanced on each rising edge from the inputs it drove half a cycle earlier. It compares the model with the outputs on every falling edge, so each result is sampled in the first cycle it is due. The scenario checks that expect fixed values (ties, saturation, lock gating, clearing) wait whole windows before sampling. Their outcome therefore does not depend on where a window boundary falls.

// File: rtl/vcal_pkg.sv
package vcal_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SWEEP = 2'd1,
        ST_READY = 2'd2,
        ST_WATCH = 2'd3
    } vcal_state_e;

    localparam logic [1:0] REF_PATH_ON = 2'b11;
endpackage

// File: rtl/vcal_refwin.sv
// Counts reference pulses and flags the pulse that closes a measurement window.
module vcal_refwin #(
    parameter int WIN_REFS = 1024,
    parameter int REF_W    = $clog2(WIN_REFS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ref_tick,
    output logic close
);
    localparam logic [REF_W-1:0] LAST_REF = REF_W'(WIN_REFS - 1);

    logic [REF_W-1:0] refs;

    assign close = run && ref_tick && (refs == LAST_REF);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || close) begin
            refs <= '0;
        end else if (ref_tick) begin
            refs <= refs + REF_W'(1);
        end
    end

    AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> (refs == '0)); // R2
endmodule

// File: rtl/vcal_vcocount.sv
// Saturating counter of divided VCO pulses within the current window.
module vcal_vcocount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             close,
    input  logic             vco_tick,
    output logic [CNT_W-1:0] meas
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;

    always_comb begin
        if (vco_tick && (cnt != CNT_MAX)) begin
            meas = cnt + CNT_W'(1);
        end else begin
            meas = cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run || close) begin
            cnt <= '0;
        end else begin
            cnt <= meas;
        end
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !close && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R8
endmodule

// File: rtl/vcal_judge.sv
// Distance to target and acceptance band test for one window count.
module vcal_judge #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] meas,
    input  logic [CNT_W-1:0] target,
    input  logic [CNT_W-1:0] tolerance,
    output logic [CNT_W-1:0] err,
    output logic             out_band
);
    logic [CNT_W:0] hi_lim;
    logic [CNT_W:0] lo_sum;

    always_comb begin
        err      = (meas >= target) ? (meas - target) : (target - meas);
        hi_lim   = {1'b0, target} + {1'b0, tolerance};
        lo_sum   = {1'b0, meas} + {1'b0, tolerance};
        out_band = ({1'b0, meas} > hi_lim) || (lo_sum < {1'b0, target});
    end
endmodule

// File: rtl/vcal_monitor.sv
// Coarse band calibration sweep and locked-state drift watch.
module vcal_monitor
    import vcal_pkg::*;
#(
    parameter int WIN_REFS = 1024,
    parameter int CNT_W    = 16,
    parameter int CODE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ref_mode,
    input  logic              ref_tick,
    input  logic              vco_tick,
    input  logic              locked,
    input  logic [CNT_W-1:0]  target,
    input  logic [CNT_W-1:0]  tolerance,
    input  logic              irq_clr,
    output logic [CODE_W-1:0] coarse_code,
    output logic              cal_done,
    output logic              drift_irq
);
    localparam int                NCODES    = 1 << CODE_W;
    localparam int                REF_W     = (WIN_REFS > 1) ? $clog2(WIN_REFS) : 1;
    localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NCODES - 1);
    localparam logic [CNT_W-1:0]  ERR_MAX   = {CNT_W{1'b1}};

    vcal_state_e       st, nxt;
    logic              mode_ok, run, close, out_band, better;
    logic [CNT_W-1:0]  meas, err, best_err;
    logic [CODE_W-1:0] code, best_code;
    logic              miss_prev, irq, irq_set;

    assign mode_ok = (ref_mode == REF_PATH_ON);
    assign run     = (st == ST_SWEEP) || (st == ST_WATCH);
    assign better  = (err < best_err);
    assign irq_set = (st == ST_WATCH) && mode_ok && locked && close && out_band && miss_prev;

    vcal_refwin #(.WIN_REFS(WIN_REFS), .REF_W(REF_W)) u_refwin (
        .clk(clk), .rst_n(rst_n), .run(run), .ref_tick(ref_tick), .close(close)
    );

    vcal_vcocount #(.CNT_W(CNT_W)) u_vcocount (
        .clk(clk), .rst_n(rst_n), .run(run), .close(close),
        .vco_tick(vco_tick), .meas(meas)
    );

    vcal_judge #(.CNT_W(CNT_W)) u_judge (
        .meas(meas), .target(target), .tolerance(tolerance),
        .err(err), .out_band(out_band)
    );

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_OFF: begin
                if (mode_ok) nxt = ST_SWEEP;
            end
            ST_SWEEP: begin
                if (!mode_ok) nxt = ST_OFF;
                else if (close && code == LAST_CODE) nxt = ST_READY;
            end
            ST_READY: begin
                if (!mode_ok) nxt = ST_OFF;
                else if (locked) nxt = ST_WATCH;
            end
            ST_WATCH: begin
                if (!mode_ok) nxt = ST_OFF;
                else if (!locked) nxt = ST_READY;
            end
            default: nxt = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_ok) begin
            code      <= '0;
            best_code <= '0;
            best_err  <= ERR_MAX;
            miss_prev <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= irq_set | (irq & ~irq_clr);
            unique case (st)
                ST_OFF: begin
                    code      <= '0;
                    best_code <= '0;
                    best_err  <= ERR_MAX;
                    miss_prev <= 1'b0;
                end
                ST_SWEEP: begin
                    if (close) begin
                        if (better) begin
                            best_code <= code;
                            best_err  <= err;
                        end
                        if (code == LAST_CODE) code <= better ? code : best_code;
                        else                   code <= code + CODE_W'(1);
                    end
                end
                ST_READY: begin
                    miss_prev <= 1'b0;
                end
                ST_WATCH: begin
                    if (!locked)    miss_prev <= 1'b0;
                    else if (close) miss_prev <= out_band;
                end
                default: miss_prev <= 1'b0;
            endcase
        end
    end

    // outputs
    always_comb begin
        coarse_code = code;
        drift_irq   = irq;
        cal_done    = (st == ST_READY) || (st == ST_WATCH);
    end

    AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_ok |=> (!cal_done && coarse_code == '0 && !drift_irq)); // R4
    AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SWEEP && mode_ok && close && coarse_code != LAST_CODE)
        |=> (coarse_code == $past(coarse_code) + CODE_W'(1))); // R2
    AST_SWEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SWEEP && mode_ok && !close) |=> $stable(coarse_code)); // R2
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done) |-> $past(st == ST_SWEEP && close && coarse_code == LAST_CODE)); // R3
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (drift_irq && !irq_clr && mode_ok) |=> drift_irq); // R7
    AST_IRQ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drift_irq) |-> $past(locked && st == ST_WATCH)); // R5
    AST_IRQ_TWO_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drift_irq) |-> $past(miss_prev && out_band && close)); // R6
endmodule

// File: tb/vcal_monitor_bench.sv
module vcal_monitor_bench;
    localparam int WIN  = 16;
    localparam int CW   = 5;
    localparam int KW   = 4;
    localparam int MAXC = (1 << CW) - 1;
    localparam int LASTK = (1 << KW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    ref_mode;
    logic          ref_tick = 1'b0;
    logic          vco_tick = 1'b0;
    logic          locked;
    logic [CW-1:0] target, tolerance;
    logic          irq_clr;
    logic [KW-1:0] coarse_code;
    logic          cal_done, drift_irq;

    always #4 clk = ~clk;

    vcal_monitor #(.WIN_REFS(WIN), .CNT_W(CW), .CODE_W(KW)) u_vcal_monitor (
        .clk(clk), .rst_n(rst_n), .ref_mode(ref_mode), .ref_tick(ref_tick),
        .vco_tick(vco_tick), .locked(locked), .target(target), .tolerance(tolerance),
        .irq_clr(irq_clr), .coarse_code(coarse_code), .cal_done(cal_done),
        .drift_irq(drift_irq)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit finished = 0;
    int force_rate = -1;
    int acc = 0;

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // pulse sources: reference every other cycle, VCO by phase accumulator
    always @(negedge clk) begin
        int rate;
        ref_tick = ~ref_tick;
        rate = (force_rate >= 0) ? force_rate : 40 + 12 * int'(coarse_code);
        acc += rate;
        if (acc >= 256) begin
            vco_tick = 1'b1;
            acc -= 256;
        end else begin
            vco_tick = 1'b0;
        end
    end

    // behavioural reference model (0 off, 1 sweep, 2 ready, 3 watch)
    int m_st = 0, m_code = 0, m_best = 0, m_best_err = MAXC;
    int m_refs = 0, m_cnt = 0, m_miss = 0, m_irq = 0;

    always @(posedge clk) begin
        int meas, e, out, run, close, st_old;
        if (!rst_n) begin
            m_st = 0; m_code = 0; m_best = 0; m_best_err = MAXC;
            m_refs = 0; m_cnt = 0; m_miss = 0; m_irq = 0;
        end else begin
            st_old = m_st;
            run   = (st_old == 1 || st_old == 3);
            close = run && ref_tick && (m_refs == WIN - 1);
            meas  = m_cnt + int'(vco_tick);
            if (meas > MAXC) meas = MAXC;
            e   = (meas > int'(target)) ? meas - int'(target) : int'(target) - meas;
            out = (meas > int'(target) + int'(tolerance)) || (meas < int'(target) - int'(tolerance));
            if (!run || close) begin m_refs = 0; m_cnt = 0; end
            else begin m_refs += int'(ref_tick); m_cnt = meas; end
            if (ref_mode != 2'b11) begin
                m_st = 0; m_code = 0; m_best = 0; m_best_err = MAXC; m_miss = 0; m_irq = 0;
            end else begin
                m_irq = (st_old == 3 && locked && close && out && m_miss) ? 1 :
                        (irq_clr ? 0 : m_irq);
                case (st_old)
                    0: begin
                        m_code = 0; m_best = 0; m_best_err = MAXC; m_miss = 0; m_st = 1;
                    end
                    1: if (close) begin
                        if (e < m_best_err) begin m_best = m_code; m_best_err = e; end
                        if (m_code == LASTK) begin m_code = m_best; m_st = 2; end
                        else m_code++;
                    end
                    2: begin m_miss = 0; if (locked) m_st = 3; end
                    default: begin
                        if (!locked) begin m_miss = 0; m_st = 2; end
                        else if (close) m_miss = out;
                    end
                endcase
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 coarse_code", int'(coarse_code), m_code);
            check("R4 cal_done", int'(cal_done), (m_st == 2 || m_st == 3) ? 1 : 0);
            check("R6 drift_irq", int'(drift_irq), m_irq);
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            if (cal_done) break;
            @(negedge clk);
        end
    endtask

    localparam int WCYC = 2 * WIN;

    initial begin
        rst_n = 1'b0; ref_mode = 2'b11; locked = 1'b0; irq_clr = 1'b0;
        target = CW'(17); tolerance = CW'(3);
        wait_cycles(3);
        check("R1 reset code", int'(coarse_code), 0);
        check("R1 reset done", int'(cal_done), 0);
        check("R1 reset irq", int'(drift_irq), 0);
        rst_n = 1'b1;
        wait_cycles(3);
        check("R1 sweep starts at code 0", int'(coarse_code), 0);
        wait_done();
        check("R3 calibration finished", int'(cal_done), 1);
        check("R3 nearest code chosen", int'(coarse_code), m_code);

        // R4: inactive setting, then restart with a silent VCO (all ties)
        ref_mode = 2'b01;
        wait_cycles(2);
        check("R4 inactive done", int'(cal_done), 0);
        check("R4 inactive code", int'(coarse_code), 0);
        force_rate = 0;
        ref_mode = 2'b11;
        wait_cycles(3);
        check("R4 restarted sweep", int'(cal_done), 0);
        wait_done();
        check("R3 tie keeps lowest code", int'(coarse_code), 0);

        // monitoring in band
        force_rate = 136;
        locked = 1'b1;
        wait_cycles(5 * WCYC);
        check("R6 in band no irq", int'(drift_irq), 0);

        // sustained drift high
        force_rate = 256;
        wait_cycles(4 * WCYC);
        check("R6 two misses set irq", int'(drift_irq), 1);

        // back in band: stays set until cleared
        force_rate = 136;
        wait_cycles(3 * WCYC);
        check("R7 irq sticky", int'(drift_irq), 1);
        irq_clr = 1'b1;
        wait_cycles(1);
        irq_clr = 1'b0;
        check("R7 irq cleared", int'(drift_irq), 0);

        // single short excursion: at most one window out of band
        force_rate = 256;
        wait_cycles(8);
        force_rate = 136;
        wait_cycles(4 * WCYC);
        check("R6 single excursion ignored", int'(drift_irq), 0);

        // drift while unlocked is not judged
        locked = 1'b0;
        force_rate = 256;
        wait_cycles(6 * WCYC);
        check("R5 unlocked no irq", int'(drift_irq), 0);
        check("R5 still calibrated", int'(cal_done), 1);

        // saturation: 32 pulses per window read as 31, inside a zero-width band at 31
        target = CW'(31); tolerance = CW'(0);
        wait_cycles(2);
        locked = 1'b1;
        wait_cycles(5 * WCYC);
        check("R8 saturated count in band", int'(drift_irq), 0);

        // reset recalibrates
        force_rate = -1; target = CW'(20); tolerance = CW'(2);
        rst_n = 1'b0;
        wait_cycles(2);
        check("R1 reset clears done", int'(cal_done), 0);
        rst_n = 1'b1;
        wait_done();
        check("R3 recalibrated code", int'(coarse_code), m_code);

        finished = 1;
        summary();
        $finish;
    end
endmodule